// File: doc/BRIEF.md
# Microcode Next-Address Dispatch Modifier

This block forms the small value that a microsequencer ORs onto the NEXT field of a microinstruction to make a multi-way branch. Each cycle a decoded function code picks one of three sources for that value:
- the instruction-register load merge;
- one of two instruction dispatches computed as combinational tables over the held instruction register;
- a single-bit test of the bus, the shifter output or the saved ALU carry.

The value is captured in a register at the clock edge. It is visible only during the following microinstruction, where it is ORed onto that instruction's NEXT field. It then falls back to zero unless a new function is issued.

The block also owns the instruction register itself, the SKIP flag that an instruction load clears, and the saved ALU carry used by the carry branch.

Field notation in the requirements numbers the 16-bit words from the MSB: field bit 0 is hardware bit 15, and field bit i is hardware bit 15-i. Modifier values are given as plain numbers, where weight 1 is hardware bit 0.

Top module: `nxt_disp_mod`

## Requirements
- R1: After a synchronous reset the registered modifier, the instruction register, SKIP and the saved carry are all zero, so next_upc equals next_field.
- R2: next_upc is next_field ORed with the modifier captured at the previous clock edge. A cycle with function code 0 (none) leaves a zero modifier for the following cycle.
- R3: Function code 1 (load IR) stores the bus into the instruction register. It also yields modifier 8·bus[15] + bus[10:8].
- R4: Function code 1 clears SKIP, even when skip_set is high in the same cycle. Otherwise skip_set high sets SKIP and SKIP holds.
- R5: For function codes 2 (instruction dispatch) and 3 (source dispatch), when IR[0]=1 the modifier is 3 minus the two-bit value IR[8-9] (hardware bits 7:6).
- R6: Function code 2 with IR[0]=0 yields IR[3-4] (hardware bits 12:11) when IR[1-2] (hardware bits 14:13) is 0. It yields 4 when IR[1-2] is 1 and 5 when IR[1-2] is 2.
- R7: Function code 2 with IR[0]=0 and IR[1-2]=3 maps v=IR[4-7] (hardware bits 11:8) as 0→1, 1→0, 6→14 and 14→6; any other v passes through unchanged.
- R8: Function code 3 with IR[0]=0 and IR[1-2]≠3 yields the indirect bit IR[5] (hardware bit 10) as the modifier.
- R9: Function code 3 with IR[0]=0 and IR[1-2]=3 maps o=IR[3-7] (hardware bits 12:8) as 0→2, 1→5, 2→3, 3→6, 4→7, 9→4, 10→4, 14→1 and 31→15; every other o gives 14.
- R10: Function code 4 yields bus[0]. Code 5 yields 1 when the whole bus is zero and 0 otherwise. Code 6 yields bus[9:0].
- R11: Function code 7 yields bit 15 of shift_out in that cycle. Code 8 yields 1 when shift_out is zero.
- R12: Function code 9 yields the carry saved by the latest earlier cycle with load_l high. A load_l in the same cycle updates the saved carry only for later cycles.
- R13: Function codes 10 to 15 yield a zero modifier and leave the instruction register and SKIP unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fn_code | input | 4 | Decoded next-address function of this microinstruction |
| bus | input | 16 | Processor bus value of this cycle |
| shift_out | input | 16 | Shifter output of this cycle |
| alu_carry | input | 1 | ALU carry of this cycle |
| load_l | input | 1 | This microinstruction loads L; saves alu_carry |
| skip_set | input | 1 | Request to set SKIP |
| next_field | input | 10 | NEXT field of the current microinstruction |
| next_upc | output | 10 | next_field ORed with the registered modifier |
| ir_out | output | 16 | Instruction register |
| skip_out | output | 1 | SKIP flag |

## Verification
On every cycle, assertions check the following:
- the clearing of the modifier after an idle cycle;
- the capture of the instruction register and the clearing of SKIP on a load;
- that the saved carry is held between L loads;
- the bus-odd and carry branches;
- the inertness of unused codes.

The content of the two dispatch tables, their priority order and the interaction of load_l with a same-cycle carry branch can only be shown by the bench. The bench sweeps every source-dispatch opcode, the shift-field cases and random instruction words against its own model.

// File: rtl/nxt_disp_pkg.sv
package nxt_disp_pkg;

  typedef enum logic [3:0] {
    FN_NONE    = 4'd0,
    FN_LOAD_IR = 4'd1,
    FN_IDISP   = 4'd2,
    FN_ACSRC   = 4'd3,
    FN_BUSODD  = 4'd4,
    FN_BUSZERO = 4'd5,
    FN_BUSDISP = 4'd6,
    FN_SHNEG   = 4'd7,
    FN_SHZERO  = 4'd8,
    FN_ALUCY   = 4'd9
  } fn_e;

  // complement of a two-bit shift field, used by arithmetic words
  function automatic logic [3:0] shift_compl(input logic [1:0] sh);
    return 4'd3 - {2'b00, sh};
  endfunction

endpackage

// File: rtl/nxt_idisp_table.sv
module nxt_idisp_table
  import nxt_disp_pkg::*;
#(
  parameter int W_DATA = 16,
  parameter int W_MOD  = 10
) (
  input  logic [W_DATA-1:0] ir,
  output logic [W_MOD-1:0]  mod
);
  localparam int B0 = W_DATA - 1;   // field bit 0 is the MSB

  logic [1:0] grp;
  logic [3:0] sub;
  logic [3:0] val;
  logic       unused_low;

  assign grp = ir[B0-1 -: 2];
  assign sub = ir[B0-4 -: 4];
  assign unused_low = ^ir[B0-10:0];

  always_comb begin
    if (ir[B0]) begin
      val = shift_compl(ir[B0-8 -: 2]);
    end else begin
      unique case (grp)
        2'd0: val = {2'b00, ir[B0-3 -: 2]};
        2'd1: val = 4'd4;
        2'd2: val = 4'd5;
        default: begin
          unique case (sub)
            4'd0:    val = 4'd1;
            4'd1:    val = 4'd0;
            4'd6:    val = 4'd14;
            4'd14:   val = 4'd6;
            default: val = sub;
          endcase
        end
      endcase
    end
    mod = '0;
    mod[3:0] = val;
  end

endmodule

// File: rtl/nxt_acsrc_table.sv
module nxt_acsrc_table
  import nxt_disp_pkg::*;
#(
  parameter int W_DATA = 16,
  parameter int W_MOD  = 10
) (
  input  logic [W_DATA-1:0] ir,
  output logic [W_MOD-1:0]  mod
);
  localparam int B0 = W_DATA - 1;

  logic [1:0] grp;
  logic [4:0] opc;
  logic [3:0] val;
  logic       unused_low;

  assign grp = ir[B0-1 -: 2];
  assign opc = ir[B0-3 -: 5];
  assign unused_low = ^ir[B0-10:0];

  always_comb begin
    if (ir[B0]) begin
      val = shift_compl(ir[B0-8 -: 2]);
    end else if (grp != 2'd3) begin
      val = {3'b000, ir[B0-5]};
    end else begin
      unique case (opc)
        5'd0:    val = 4'd2;
        5'd1:    val = 4'd5;
        5'd2:    val = 4'd3;
        5'd3:    val = 4'd6;
        5'd4:    val = 4'd7;
        5'd9:    val = 4'd4;
        5'd10:   val = 4'd4;
        5'd14:   val = 4'd1;
        5'd31:   val = 4'd15;
        default: val = 4'd14;
      endcase
    end
    mod = '0;
    mod[3:0] = val;
  end

endmodule

// File: rtl/nxt_cond_mod.sv
module nxt_cond_mod
  import nxt_disp_pkg::*;
#(
  parameter int W_DATA = 16,
  parameter int W_MOD  = 10
) (
  input  logic [3:0]        fn_code,
  input  logic [W_DATA-1:0] bus,
  input  logic [W_DATA-1:0] shift_out,
  input  logic              carry_q,
  output logic [W_MOD-1:0]  mod
);
  localparam int B0 = W_DATA - 1;

  always_comb begin
    mod = '0;
    case (fn_code)
      FN_LOAD_IR: begin
        mod[3]   = bus[B0];
        mod[2:0] = bus[B0-5 -: 3];
      end
      FN_BUSODD:  mod[0] = bus[0];
      FN_BUSZERO: mod[0] = (bus == '0);
      FN_BUSDISP: mod    = bus[W_MOD-1:0];
      FN_SHNEG:   mod[0] = shift_out[B0];
      FN_SHZERO:  mod[0] = (shift_out == '0);
      FN_ALUCY:   mod[0] = carry_q;
      default:    mod    = '0;
    endcase
  end

endmodule

// File: rtl/nxt_disp_mod.sv
module nxt_disp_mod
  import nxt_disp_pkg::*;
#(
  parameter int W_DATA = 16,
  parameter int W_MOD  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        fn_code,
  input  logic [W_DATA-1:0] bus,
  input  logic [W_DATA-1:0] shift_out,
  input  logic              alu_carry,
  input  logic              load_l,
  input  logic              skip_set,
  input  logic [W_MOD-1:0]  next_field,
  output logic [W_MOD-1:0]  next_upc,
  output logic [W_DATA-1:0] ir_out,
  output logic              skip_out
);
  logic [W_MOD-1:0]  mod_q, mod_d;
  logic [W_MOD-1:0]  idisp_m, acsrc_m, cond_m;
  logic [W_DATA-1:0] ir_q;
  logic              skip_q, carry_q;

  nxt_idisp_table #(.W_DATA(W_DATA), .W_MOD(W_MOD)) u_idisp (
    .ir(ir_q), .mod(idisp_m));

  nxt_acsrc_table #(.W_DATA(W_DATA), .W_MOD(W_MOD)) u_acsrc (
    .ir(ir_q), .mod(acsrc_m));

  nxt_cond_mod #(.W_DATA(W_DATA), .W_MOD(W_MOD)) u_cond (
    .fn_code(fn_code), .bus(bus), .shift_out(shift_out),
    .carry_q(carry_q), .mod(cond_m));

  always_comb begin
    case (fn_code)
      FN_IDISP: mod_d = idisp_m;
      FN_ACSRC: mod_d = acsrc_m;
      default:  mod_d = cond_m;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_q   <= '0;
      ir_q    <= '0;
      skip_q  <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      mod_q <= mod_d;
      if (fn_code == FN_LOAD_IR) ir_q <= bus;
      if (fn_code == FN_LOAD_IR) skip_q <= 1'b0;
      else if (skip_set)         skip_q <= 1'b1;
      if (load_l) carry_q <= alu_carry;
    end
  end

  assign next_upc = next_field | mod_q;
  assign ir_out   = ir_q;
  assign skip_out = skip_q;

  // R2: an idle function leaves the following NEXT untouched
  a_r2_idle_clears: assert property (@(posedge clk) disable iff (rst)
    (fn_code == FN_NONE) |=> (next_upc == next_field));

  a_r3_ir_capture: assert property (@(posedge clk) disable iff (rst)
    (fn_code == FN_LOAD_IR) |=> (ir_out == $past(bus)));

  a_r4_skip_clear: assert property (@(posedge clk) disable iff (rst)
    (fn_code == FN_LOAD_IR) |=> !skip_out);

  a_r12_carry_hold: assert property (@(posedge clk) disable iff (rst)
    !load_l |=> $stable(carry_q));

  a_r12_alucy_old: assert property (@(posedge clk) disable iff (rst)
    (fn_code == FN_ALUCY) |=> (mod_q == {{(W_MOD-1){1'b0}}, $past(carry_q)}));

  a_r10_busodd: assert property (@(posedge clk) disable iff (rst)
    (fn_code == FN_BUSODD) |=> (mod_q == {{(W_MOD-1){1'b0}}, $past(bus[0])}));

  a_r13_unused_inert: assert property (@(posedge clk) disable iff (rst)
    (fn_code >= 4'd10) |=> (mod_q == '0 && $stable(ir_q)));

endmodule

// File: tb/test_nxt_disp_mod.sv
module test_nxt_disp_mod;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  fn_code;
  logic [15:0] bus, shift_out;
  logic        alu_carry, load_l, skip_set;
  logic [9:0]  next_field;
  logic [9:0]  next_upc;
  logic [15:0] ir_out;
  logic        skip_out;

  int checks = 0;
  int fails  = 0;
  int m_mod = 0, m_ir = 0, m_skip = 0, m_carry = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nxt_disp_mod i_nxt_disp_mod (
    .clk(clk), .rst(rst), .fn_code(fn_code), .bus(bus), .shift_out(shift_out),
    .alu_carry(alu_carry), .load_l(load_l), .skip_set(skip_set),
    .next_field(next_field), .next_upc(next_upc), .ir_out(ir_out),
    .skip_out(skip_out));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_idisp(int ir);
    int g, v;
    if (ir & 'h8000) return 3 - ((ir >> 6) & 3);
    g = (ir >> 13) & 3;
    if (g == 0) return (ir >> 11) & 3;
    if (g == 1) return 4;
    if (g == 2) return 5;
    v = (ir >> 8) & 15;
    if (v == 0) return 1;
    if (v == 1) return 0;
    if (v == 6) return 14;
    if (v == 14) return 6;
    return v;
  endfunction

  function automatic int ref_acsrc(int ir);
    int o;
    if (ir & 'h8000) return 3 - ((ir >> 6) & 3);
    if (((ir >> 13) & 3) != 3) return (ir >> 10) & 1;
    o = (ir >> 8) & 31;
    case (o)
      0: return 2;   1: return 5;   2: return 3;   3: return 6;
      4: return 7;   9: return 4;   10: return 4;  14: return 1;
      31: return 15;
      default: return 14;
    endcase
  endfunction

  function automatic int ref_mod(int fn, int b, int sh);
    case (fn)
      1: return ((b >> 15) & 1) * 8 + ((b >> 8) & 7);
      2: return ref_idisp(m_ir);
      3: return ref_acsrc(m_ir);
      4: return b & 1;
      5: return (b == 0) ? 1 : 0;
      6: return b & 1023;
      7: return (sh >> 15) & 1;
      8: return (sh == 0) ? 1 : 0;
      9: return m_carry;
      default: return 0;
    endcase
  endfunction

  // one microinstruction cycle; checks the outputs just after the edge
  task automatic cyc(string tag, int fn, int b, int sh = 0, int nf = 0,
                     int ll = 0, int ac = 0, int ss = 0);
    int e;
    @(negedge clk);
    fn_code = fn[3:0]; bus = b[15:0]; shift_out = sh[15:0];
    next_field = nf[9:0]; load_l = ll[0]; alu_carry = ac[0]; skip_set = ss[0];
    e = ref_mod(fn, b, sh);
    @(posedge clk);
    #2;
    m_mod = e;
    if (fn == 1) begin m_ir = b & 'hffff; m_skip = 0; end
    else if (ss != 0) m_skip = 1;
    if (ll != 0) m_carry = ac & 1;
    chk(tag, int'(next_upc), nf | m_mod);
    chk(tag, int'(ir_out), m_ir);
    chk(tag, int'(skip_out), m_skip);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; fn_code = 4'd1; bus = 16'hffff; shift_out = '0;
    alu_carry = 1'b1; load_l = 1'b1; skip_set = 1'b1; next_field = 10'h155;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1", int'(next_upc), 'h155);
    chk("R1", int'(ir_out), 0);
    chk("R1", int'(skip_out), 0);
    @(negedge clk);
    rst = 1'b0; fn_code = 4'd0; load_l = 1'b0; skip_set = 1'b0; alu_carry = 1'b0;
    cyc("R1", 9, 0, 0, 'h200);   // carry after reset must be zero

    // R3 load merge patterns
    cyc("R3", 1, 'h8700, 0, 'h100);
    cyc("R2", 0, 'h0, 0, 'h100);          // modifier gone next cycle
    cyc("R3", 1, 'h0500);
    cyc("R3", 1, 'h78ff);
    cyc("R2", 0, 'h1234, 0, 'h3f0);

    // R4 SKIP behaviour
    cyc("R4", 0, 0, 0, 0, 0, 0, 1);
    cyc("R4", 0, 0);
    cyc("R4", 1, 'h1234, 0, 0, 0, 0, 1);  // load wins over set
    cyc("R4", 0, 0, 0, 0, 0, 0, 1);

    // R5 arithmetic shift field for both dispatches
    for (int s = 0; s < 4; s++) begin
      cyc("R5", 1, 'h8000 | (s << 6) | 'h2a00);
      cyc("R5", 2, 0, 0, 'h3c0);
      cyc("R5", 3, 0);
    end

    // R6/R7 instruction dispatch groups and remaps
    for (int g = 0; g < 3; g++) begin
      cyc("R6", 1, (g << 13) | 'h1800);
      cyc("R6", 2, 0);
    end
    for (int v = 0; v < 16; v++) begin
      cyc("R7", 1, 'h6000 | (v << 8));
      cyc("R7", 2, 0);
    end

    // R8 indirect bit, R9 full opcode sweep
    for (int g = 0; g < 3; g++) begin
      cyc("R8", 1, (g << 13) | 'h0400);
      cyc("R8", 3, 0);
      cyc("R8", 1, (g << 13) | 'h1b00);
      cyc("R8", 3, 0);
    end
    for (int o = 0; o < 32; o++) begin
      cyc("R9", 1, 'h6000 | (o << 8));
      cyc("R9", 3, 0, 0, 'h200);
    end

    // R10 bus tests
    cyc("R10", 4, 'h0001);
    cyc("R10", 4, 'hfffe);
    cyc("R10", 5, 'h0000);
    cyc("R10", 5, 'h8000);
    cyc("R10", 6, 'hfd5a, 0, 'h001);

    // R11 shifter tests
    cyc("R11", 7, 0, 'h8000);
    cyc("R11", 7, 0, 'h7fff);
    cyc("R11", 8, 0, 'h0000);
    cyc("R11", 8, 0, 'h0010);

    // R12 carry save and late use
    cyc("R12", 0, 0, 0, 0, 1, 1);
    cyc("R12", 9, 0, 0, 0, 1, 0);         // still sees saved 1
    cyc("R12", 9, 0);                      // now 0
    cyc("R12", 0, 0, 0, 0, 0, 1);          // carry without load_l ignored
    cyc("R12", 9, 0);

    // R13 unused codes
    cyc("R13", 1, 'h4321, 0, 0, 0, 0, 0);
    cyc("R13", 0, 0, 0, 0, 0, 0, 1);
    for (int f = 10; f < 16; f++) cyc("R13", f, 'hffff, 'h0, 'h0);

    // random mix of dispatches
    for (int i = 0; i < 200; i++) begin
      int w;
      w = int'($urandom_range(0, 65535));
      cyc("R3", 1, w);
      cyc("R7", 2, 0, 0, int'($urandom_range(0, 1023)));
      cyc("R9", 3, 0);
    end

    done = 1;
    finish_run();
  end
endmodule